// File: doc/BRIEF.md
# Bit-Sliced Configurable ALU

This block is a purely combinational arithmetic and logic unit, 8 bits wide by default. It is built as a row of identical bit slices. Before any operation, each slice can invert its A operand, invert its B operand, and force B to zero. Every slice then forms the sum, AND, OR and XOR of the conditioned operands, along with pass-through and neighbour-bit values. A 3-bit select picks one of these as the output bit.

A flattened carry lookahead network produces every slice carry and the carry-out in two logic levels, with no ripple chain. The operand controls and the carry input, which acts as an inverted borrow, let the single adder perform several operations:
- addition with carry;
- subtraction with borrow;
- reverse subtraction;
- increment, decrement and negate.

The same controls yield every inverted-input logic function. A right shift is logical or arithmetic, and the choice is made only at the top slice.

Around the block, a controller drives operands, carry and the control word, and takes the result and the four condition flags in the same cycle.

Top module: `bs_alu`

## Requirements
- R1: The control word is ctrl_i[2:0] = select, ctrl_i[3] = invert A, ctrl_i[4] = invert B, ctrl_i[5] = zero B. The conditioned operands are A' = invert A ? ~A : A and B' = (zero B ? 0 : B) XOR invert B. Every selection acts on A' and B'.
- R2: Select 1 (sum) gives X = (A' + B' + carry_i) mod 2^W, and C = the carry out of the top bit.
- R3: carry_i acts as an inverted borrow. With invert B set, carry_i = 1 yields A-B and carry_i = 0 yields A-B-1. With invert A set and invert B clear, carry_i = 1 yields B-A.
- R4: Under select 1 the derived unary operations are:
  - increment: zero B, carry 1;
  - decrement: zero B, invert B, carry 0;
  - negate: invert A, zero B, carry 1.
- R5: The logic and pass-through selects are:
  - select 2: A' AND B';
  - select 3: A' OR B';
  - select 4: A' XOR B';
  - select 5: A';
  - select 6: B'.
- R6: Select 0 gives X = A' shifted left by one with a 0 entering the LSB. C is the bit shifted out, A'[W-1].
- R7: Select 7 shifts A' right by one. With invert B set (logical) the MSB becomes 0. With invert B clear (arithmetic) the MSB keeps A'[W-1].
- R8: Under select 1, V = (carry into bit W-1) XOR (carry out of bit W-1). This means V = 1 exactly when A' and B' share a sign bit that differs from the sign bit of X.
- R9: For selects 2 to 7, C and V are 0. For select 0, V is 0. carry_i has no effect on X for any select other than 1.
- R10: Z is 1 exactly when X is all zeros, and N equals X[W-1], for every select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Carry in (inverted borrow) |
| ctrl_i | input | 6 | Control word: select, invert A, invert B, zero B |
| x_o | output | 8 | Result |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |

## Verification
The block holds no state, so any fault in a conditioned operand, a lookahead carry term or a slice multiplexer appears at x_o and the flags in the same evaluation that applies the inputs. A missing product term in the carry network only shows when a propagate run of the matching length meets a generate or the carry input. The operand sweep therefore pairs all-ones and all-zeros patterns with both carry values. A wrong top-slice shift variant shows only under select 7 with a set sign bit, and the flag logic is exposed by the operand pairs at the signed and unsigned wrap points.

// File: rtl/bs_alu_pkg.sv
package bs_alu_pkg;
  typedef enum logic [2:0] {
    SEL_SHL    = 3'd0,
    SEL_SUM    = 3'd1,
    SEL_AND    = 3'd2,
    SEL_OR     = 3'd3,
    SEL_XOR    = 3'd4,
    SEL_PASS_A = 3'd5,
    SEL_PASS_B = 3'd6,
    SEL_SHR    = 3'd7
  } sel_e;

  localparam int CTRL_W     = 6;
  localparam int CTRL_INV_A = 3;
  localparam int CTRL_INV_B = 4;
  localparam int CTRL_ZERO_B = 5;
endpackage

// File: rtl/bs_alu_prep.sv
module bs_alu_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             zero_b_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  logic [WIDTH-1:0] b_gated;

  assign a_o     = a_i ^ {WIDTH{inv_a_i}};
  // zero first, then invert: zero+invert yields all ones
  assign b_gated = zero_b_i ? '0 : b_i;
  assign b_o     = b_gated ^ {WIDTH{inv_b_i}};
endmodule

// File: rtl/bs_alu_cla.sv
module bs_alu_cla #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH:0]   carry_o
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic             acc;
  logic             run;

  assign gen  = a_i & b_i;
  assign prop = a_i | b_i;

  // flattened sum of products per carry, no ripple path
  always_comb begin
    carry_o[0] = carry_i;
    acc = 1'b0;
    run = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      acc = gen[i];
      run = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      acc = acc | (run & carry_i);
      carry_o[i+1] = acc;
    end
  end
endmodule

// File: rtl/bs_alu_slice.sv
module bs_alu_slice
  import bs_alu_pkg::*;
(
  input  logic a_lo_i,
  input  logic a_i,
  input  logic a_hi_i,
  input  logic b_i,
  input  logic c_i,
  input  sel_e sel_i,
  output logic x_o
);
  always_comb begin
    unique case (sel_i)
      SEL_SHL:    x_o = a_lo_i;
      SEL_SUM:    x_o = a_i ^ b_i ^ c_i;
      SEL_AND:    x_o = a_i & b_i;
      SEL_OR:     x_o = a_i | b_i;
      SEL_XOR:    x_o = a_i ^ b_i;
      SEL_PASS_A: x_o = a_i;
      SEL_PASS_B: x_o = b_i;
      SEL_SHR:    x_o = a_hi_i;
      default:    x_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bs_alu_flags.sv
module bs_alu_flags
  import bs_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  sel_e             sel_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic             cout_i,
  input  logic             cmsb_i,
  input  logic             a_msb_i,
  output logic             c_o,
  output logic             v_o,
  output logic             z_o,
  output logic             n_o
);
  always_comb begin
    c_o = 1'b0;
    v_o = 1'b0;
    if (sel_i == SEL_SUM) begin
      c_o = cout_i;
      v_o = cout_i ^ cmsb_i;
    end else if (sel_i == SEL_SHL) begin
      c_o = a_msb_i;
    end
  end

  assign z_o = ~|x_i;
  assign n_o = x_i[WIDTH-1];
endmodule

// File: rtl/bs_alu.sv
module bs_alu
  import bs_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic              carry_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  x_o,
  output logic              c_o,
  output logic              v_o,
  output logic              z_o,
  output logic              n_o
);
  localparam int MSB = WIDTH - 1;

  sel_e             sel;
  logic             asr;
  logic [WIDTH-1:0] a_op;
  logic [WIDTH-1:0] b_op;
  logic [WIDTH:0]   carry;

  assign sel = sel_e'(ctrl_i[2:0]);
  // invert-B is meaningless for a shift: reused as logical/arithmetic choice
  assign asr = ~ctrl_i[CTRL_INV_B];

  bs_alu_prep #(.WIDTH(WIDTH)) u_prep (
    .a_i      (a_i),
    .b_i      (b_i),
    .inv_a_i  (ctrl_i[CTRL_INV_A]),
    .inv_b_i  (ctrl_i[CTRL_INV_B]),
    .zero_b_i (ctrl_i[CTRL_ZERO_B]),
    .a_o      (a_op),
    .b_o      (b_op)
  );

  bs_alu_cla #(.WIDTH(WIDTH)) u_cla (
    .a_i     (a_op),
    .b_i     (b_op),
    .carry_i (carry_i),
    .carry_o (carry)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic a_lo;
    logic a_hi;
    if (i == 0) begin : g_lsb
      assign a_lo = 1'b0;
    end else begin : g_lo
      assign a_lo = a_op[i-1];
    end
    if (i == MSB) begin : g_msb
      assign a_hi = asr & a_op[i];
    end else begin : g_hi
      assign a_hi = a_op[i+1];
    end

    bs_alu_slice u_slice (
      .a_lo_i (a_lo),
      .a_i    (a_op[i]),
      .a_hi_i (a_hi),
      .b_i    (b_op[i]),
      .c_i    (carry[i]),
      .sel_i  (sel),
      .x_o    (x_o[i])
    );
  end

  bs_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .sel_i   (sel),
    .x_i     (x_o),
    .cout_i  (carry[WIDTH]),
    .cmsb_i  (carry[MSB]),
    .a_msb_i (a_op[MSB]),
    .c_o     (c_o),
    .v_o     (v_o),
    .z_o     (z_o),
    .n_o     (n_o)
  );
endmodule

// File: rtl/bs_alu_chk.sv
module bs_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [5:0]       ctrl_i,
  input logic [WIDTH-1:0] x_o,
  input logic             c_o,
  input logic             v_o,
  input logic             z_o,
  input logic             n_o
);
  logic [WIDTH-1:0] a_ref;
  logic [WIDTH-1:0] b_ref;
  logic [WIDTH:0]   sum_ref;
  logic [2:0]       sel;
  logic             ovf_ref;

  assign sel     = ctrl_i[2:0];
  assign a_ref   = ctrl_i[3] ? ~a_i : a_i;
  assign b_ref   = ctrl_i[5] ? {WIDTH{ctrl_i[4]}} : (ctrl_i[4] ? ~b_i : b_i);
  assign sum_ref = {1'b0, a_ref} + {1'b0, b_ref} + {{WIDTH{1'b0}}, carry_i};
  assign ovf_ref = (a_ref[WIDTH-1] == b_ref[WIDTH-1]) && (x_o[WIDTH-1] != a_ref[WIDTH-1]);

  always_comb begin
    // R2
    sum_chk: assert (sel != 3'd1 || {c_o, x_o} == sum_ref)
      else $error("sum mismatch");
    // R8
    overflow_chk: assert (sel != 3'd1 || v_o == ovf_ref)
      else $error("overflow mismatch");
    // R9
    no_flag_chk: assert (sel == 3'd1 || sel == 3'd0 || (!c_o && !v_o))
      else $error("flags not clear");
    // R6
    shl_chk: assert (sel != 3'd0 || ({c_o, x_o} == {a_ref, 1'b0} && !v_o))
      else $error("shift left mismatch");
    // R7
    shr_chk: assert (sel != 3'd7 ||
                     x_o == {(~ctrl_i[4] & a_ref[WIDTH-1]), a_ref[WIDTH-1:1]})
      else $error("shift right mismatch");
    // R5
    and_chk: assert (sel != 3'd2 || x_o == (a_ref & b_ref))
      else $error("and mismatch");
    // R10
    zero_chk: assert (z_o == (x_o == '0))
      else $error("zero flag mismatch");
    // R10
    neg_chk: assert (n_o == x_o[WIDTH-1])
      else $error("negative flag mismatch");
  end
endmodule

bind bs_alu bs_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .carry_i (carry_i),
  .ctrl_i  (ctrl_i),
  .x_o     (x_o),
  .c_o     (c_o),
  .v_o     (v_o),
  .z_o     (z_o),
  .n_o     (n_o)
);

// File: tb/bs_alu_tb.sv
module bs_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, x;
  logic         cin;
  logic [5:0]   ctrl;
  logic         c, v, z, n;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bs_alu u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .ctrl_i(ctrl),
    .x_o(x), .c_o(c), .v_o(v), .z_o(z), .n_o(n)
  );

  function automatic logic [5:0] mk(int sel, bit ia, bit ib, bit zb);
    return {zb, ib, ia, 3'(sel)};
  endfunction

  function automatic logic [11:0] ex(bit ec, bit ev, bit ez, bit en, logic [7:0] ex_x);
    return {ec, ev, ez, en, ex_x};
  endfunction

  // behavioural model from the requirements
  function automatic logic [11:0] ref_alu(logic [7:0] ra, logic [7:0] rb, bit rc, logic [5:0] rctl);
    logic [7:0] ap, bp, rx;
    logic [8:0] s;
    logic [7:0] lo7;
    bit rcf, rvf, c7;
    ap = rctl[3] ? ~ra : ra;
    bp = rctl[5] ? 8'h00 : rb;
    if (rctl[4]) bp = ~bp;
    s = {1'b0, ap} + {1'b0, bp} + {8'h00, rc};
    lo7 = {1'b0, ap[6:0]} + {1'b0, bp[6:0]} + {7'h00, rc};
    c7 = lo7[7];
    rcf = 1'b0; rvf = 1'b0;
    case (rctl[2:0])
      3'd0: begin rx = {ap[6:0], 1'b0}; rcf = ap[7]; end
      3'd1: begin rx = s[7:0]; rcf = s[8]; rvf = s[8] ^ c7; end
      3'd2: rx = ap & bp;
      3'd3: rx = ap | bp;
      3'd4: rx = ap ^ bp;
      3'd5: rx = ap;
      3'd6: rx = bp;
      default: rx = {(~rctl[4] & ap[7]), ap[7:1]};
    endcase
    return {rcf, rvf, (rx == 8'h00), rx[7], rx};
  endfunction

  task automatic apply(logic [7:0] ta, logic [7:0] tb_, bit tc, logic [5:0] tctl);
    @(negedge clk);
    a = ta; b = tb_; cin = tc; ctrl = tctl;
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(string req, logic [11:0] exp_v);
    logic [11:0] got;
    got = {c, v, z, n, x};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d ctrl=%b got cvzn=%b x=%h expected cvzn=%b x=%h",
               req, a, b, cin, ctrl, got[11:8], got[7:0], exp_v[11:8], exp_v[7:0]);
    end
  endtask

  task automatic t_idle();
    apply(8'h00, 8'h00, 1'b0, 6'd0);
    chk("R10 idle zero", ex(0, 0, 1, 0, 8'h00));
  endtask

  task automatic t_add();
    apply(8'h7F, 8'h01, 0, mk(1, 0, 0, 0)); chk("R2 R8 add signed wrap", ex(0, 1, 0, 1, 8'h80));
    apply(8'hFF, 8'h01, 0, mk(1, 0, 0, 0)); chk("R2 add carry out", ex(1, 0, 1, 0, 8'h00));
    apply(8'h12, 8'h34, 1, mk(1, 0, 0, 0)); chk("R2 add with carry", ex(0, 0, 0, 0, 8'h47));
    apply(8'hFF, 8'h00, 1, mk(1, 0, 0, 0)); chk("R2 full carry run", ex(1, 0, 1, 0, 8'h00));
  endtask

  task automatic t_sub();
    apply(8'h50, 8'h20, 1, mk(1, 0, 1, 0)); chk("R3 sub no borrow", ex(1, 0, 0, 0, 8'h30));
    apply(8'h50, 8'h20, 0, mk(1, 0, 1, 0)); chk("R3 sub with borrow", ex(1, 0, 0, 0, 8'h2F));
    apply(8'h20, 8'h50, 1, mk(1, 0, 1, 0)); chk("R3 sub negative", ex(0, 0, 0, 1, 8'hD0));
    apply(8'h80, 8'h01, 1, mk(1, 0, 1, 0)); chk("R3 R8 sub overflow", ex(1, 1, 0, 0, 8'h7F));
    apply(8'h20, 8'h50, 1, mk(1, 1, 0, 0)); chk("R3 reverse sub", ex(1, 0, 0, 0, 8'h30));
  endtask

  task automatic t_unary();
    apply(8'hFF, 8'h5A, 1, mk(1, 0, 0, 1)); chk("R4 inc wrap", ex(1, 0, 1, 0, 8'h00));
    apply(8'h7F, 8'h5A, 1, mk(1, 0, 0, 1)); chk("R4 inc overflow", ex(0, 1, 0, 1, 8'h80));
    apply(8'h00, 8'h5A, 0, mk(1, 0, 1, 1)); chk("R4 dec wrap", ex(0, 0, 0, 1, 8'hFF));
    apply(8'h80, 8'h5A, 0, mk(1, 0, 1, 1)); chk("R4 dec overflow", ex(1, 1, 0, 0, 8'h7F));
    apply(8'h01, 8'h5A, 1, mk(1, 1, 0, 1)); chk("R4 neg one", ex(0, 0, 0, 1, 8'hFF));
    apply(8'h80, 8'h5A, 1, mk(1, 1, 0, 1)); chk("R4 neg min", ex(0, 1, 0, 1, 8'h80));
    apply(8'h00, 8'h5A, 1, mk(1, 1, 0, 1)); chk("R4 neg zero", ex(1, 0, 1, 0, 8'h00));
  endtask

  task automatic t_logic();
    apply(8'hCC, 8'hAA, 0, mk(2, 0, 0, 0)); chk("R5 and", ex(0, 0, 0, 1, 8'h88));
    apply(8'hCC, 8'hAA, 1, mk(2, 0, 0, 0)); chk("R9 and ignores carry", ex(0, 0, 0, 1, 8'h88));
    apply(8'hCC, 8'hAA, 0, mk(3, 0, 0, 0)); chk("R5 or", ex(0, 0, 0, 1, 8'hEE));
    apply(8'hCC, 8'hAA, 0, mk(4, 0, 0, 0)); chk("R5 xor", ex(0, 0, 0, 0, 8'h66));
    apply(8'hCC, 8'hAA, 0, mk(2, 1, 1, 0)); chk("R1 nor", ex(0, 0, 0, 0, 8'h11));
    apply(8'hCC, 8'hAA, 0, mk(2, 1, 0, 0)); chk("R1 and inv a", ex(0, 0, 0, 0, 8'h22));
    apply(8'hCC, 8'hAA, 0, mk(2, 0, 1, 0)); chk("R1 and inv b", ex(0, 0, 0, 0, 8'h44));
    apply(8'hCC, 8'hAA, 0, mk(3, 1, 1, 0)); chk("R1 nand", ex(0, 0, 0, 0, 8'h77));
    apply(8'hCC, 8'hAA, 0, mk(4, 0, 1, 0)); chk("R1 xnor", ex(0, 0, 0, 1, 8'h99));
    apply(8'hCC, 8'hAA, 0, mk(2, 0, 0, 1)); chk("R1 and zero b", ex(0, 0, 1, 0, 8'h00));
    apply(8'hCC, 8'hAA, 0, mk(5, 1, 0, 0)); chk("R5 pass inv a", ex(0, 0, 0, 0, 8'h33));
    apply(8'hCC, 8'hAA, 0, mk(6, 0, 1, 0)); chk("R5 pass inv b", ex(0, 0, 0, 0, 8'h55));
    apply(8'hCC, 8'hAA, 0, mk(6, 0, 0, 1)); chk("R1 pass zero b", ex(0, 0, 1, 0, 8'h00));
    apply(8'hCC, 8'hAA, 0, mk(6, 0, 1, 1)); chk("R1 pass ones", ex(0, 0, 0, 1, 8'hFF));
  endtask

  task automatic t_shift();
    apply(8'h81, 8'h00, 0, mk(0, 0, 0, 0)); chk("R6 shl carry out", ex(1, 0, 0, 0, 8'h02));
    apply(8'h40, 8'h00, 1, mk(0, 0, 0, 0)); chk("R6 shl into sign", ex(0, 0, 0, 1, 8'h80));
    apply(8'h81, 8'h00, 0, mk(0, 1, 0, 0)); chk("R6 shl inv a", ex(0, 0, 0, 1, 8'hFC));
    apply(8'h81, 8'h00, 0, mk(7, 0, 1, 0)); chk("R7 shr logical", ex(0, 0, 0, 0, 8'h40));
    apply(8'h81, 8'h00, 1, mk(7, 0, 0, 0)); chk("R7 shr arithmetic", ex(0, 0, 0, 1, 8'hC0));
    apply(8'h42, 8'h00, 0, mk(7, 0, 0, 0)); chk("R7 shr arith positive", ex(0, 0, 0, 0, 8'h21));
    apply(8'h01, 8'h00, 0, mk(7, 0, 1, 0)); chk("R7 shr to zero", ex(0, 0, 1, 0, 8'h00));
    apply(8'h01, 8'h00, 0, mk(7, 1, 0, 0)); chk("R7 shr arith inv a", ex(0, 0, 0, 1, 8'hFF));
  endtask

  task automatic t_sweep();
    logic [7:0] corner [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int k = 0; k < 64; k++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int ia = 0; ia < 4; ia++) begin
          for (int ib = 0; ib < 4; ib++) begin
            apply(corner[ia], corner[ib], ci[0], 6'(k));
            chk("R1/R2/R5/R8/R9/R10 corner sweep", ref_alu(corner[ia], corner[ib], ci[0], 6'(k)));
          end
        end
      end
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 600; k++) begin
      logic [7:0] ra, rb;
      logic [5:0] rctl;
      bit rc;
      ra = 8'($urandom); rb = 8'($urandom); rctl = 6'($urandom); rc = 1'($urandom);
      apply(ra, rb, rc, rctl);
      chk("R1/R6/R7/R10 random", ref_alu(ra, rb, rc, rctl));
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; ctrl = '0;
    t_idle();
    t_add();
    t_sub();
    t_unary();
    t_logic();
    t_shift();
    t_sweep();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule